// File: doc/BRIEF.md
# Block-Paced Host Transfer Bridge

The bridge connects a byte-addressed host bus to a byte-wide handshake on the disk-bus side. Bulk data does not move through a data register one byte at a time. It moves through a single shared window of 128 bytes, a whole block at a time. The host sets the direction bit in the control register and then writes the number of blocks into the count register. Writing a non-zero count starts the transfer. Before each block, the host polls the not-ready flag in the status register. When the flag is clear, the host reads or writes the whole window in one burst. The bridge handles the disk-bus side by itself, using a request/acknowledge handshake.

While a counted transfer runs, the register space of the bus-controller core is locked. Reads from that space return 0xFF, and the core chip-select stays low. The lock lifts only when the final block has left the window. At that moment the bridge also sets a completion status bit and can raise an interrupt. A disconnect indication from the core suspends the handshake, and a resume strobe from the host releases it. A control write with bit 7 set aborts everything.

Top module: `blkdma_bridge`

## Requirements
- R1: After reset the status register (address 0x00) reads 0x84 and the count register (address 0x01) reads 0. Status bit positions: 7 access, 6 direction, 5 ready-interrupt enable, 4 core-interrupt enable, 3 shared mode, 2 not-ready, 1 disk-side ready, 0 done.
- R2: Writing a non-zero count while idle starts a transfer. The access bit clears, and the count register reads back the written value. A count written as zero starts nothing.
- R3: With direction 1 (disk to host), the disk-side bytes fill window offsets 0 to 127 in arrival order. Not-ready clears only after offset 127 is stored. Host reads of window addresses 0x80+offset then return those bytes.
- R4: With direction 1, a host read of offset 127 ends the block. The count decrements, and if blocks remain, not-ready sets again and filling restarts at offset 0.
- R5: With direction 0 (host to disk), a host write of offset 127 sets not-ready. The window then drains to scsi_dout in offset order, one byte per cycle in which scsi_req and scsi_ack are both high. The count decrements when offset 127 leaves.
- R6: When the count reaches zero and the last byte has left the window, the bridge returns to idle. Status then shows access=1, not-ready=1 and done=1.
- R7: While not-ready is set, host writes to the window are ignored, and host reads of the window return 0xFF.
- R8: core_cs pulses for host accesses to addresses 0x08 to 0x0F only when access is 1. While access is 0, reads there return 0xFF.
- R9: host_irq is the OR of two terms. The first is bit 5 AND (the window is ready for the host during a transfer). The second is bit 4 AND (core_irq OR done).
- R10: With bit 3 set, host_irq_oe equals host_irq. With bit 3 clear, host_irq_oe is 1.
- R11: A control write with bit 7 set aborts any transfer and clears all control bits. Status then reads 0x84 and the count reads 0.
- R12: A scsi_disc pulse during a transfer holds scsi_ack low until the host writes address 0x02.
- R13: Status bit 1 is set only while the disk side owns the window and the bridge is not suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 8 | Host address: bit 7 selects the window, otherwise a register |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational in the strobe cycle |
| host_irq | output | 1 | Interrupt request |
| host_irq_oe | output | 1 | Interrupt line drive enable |
| scsi_req | input | 1 | Disk side offers a byte (direction 1) or wants one (direction 0) |
| scsi_ack | output | 1 | Bridge can take or give a byte this cycle |
| scsi_din | input | 8 | Byte from the disk side |
| scsi_dout | output | 8 | Byte to the disk side |
| scsi_disc | input | 1 | Disconnect pulse, suspends the handshake |
| core_cs | output | 1 | Chip-select to the controller core registers |
| core_we | output | 1 | Write qualifier for core_cs |
| core_rdata | input | 8 | Read data from the controller core |
| core_irq | input | 1 | Interrupt from the controller core |

## Verification
Most faults in the block counter or the window pointer show up within one block at the ports. A miscounted block keeps the access bit clear after the last expected block. It can also end the transfer early, and a host read of the count register shows the error at the next block boundary. A pointer that is off by one or restarts wrongly shifts every byte after it. The host read-back or the captured scsi_dout stream then shows the shift from the first wrong offset. A wrong ownership or suspend state shows up as not-ready, disk-side-ready or scsi_ack levels that disagree with the phase of the transfer, and it is visible in the next status read.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

  // Control bits held by the bridge, in status bit order 6..3
  typedef struct packed {
    logic dir;      // 1: disk side to host
    logic en_rdy;   // interrupt while window ready for host
    logic en_core;  // pass core interrupt and done
    logic shared;   // drive the interrupt line only when asserted
  } ctl_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_CNT, SEL_RESUME, SEL_CORE, SEL_WIN
  } sel_e;

  function automatic logic [7:0] pack_status(input logic access, input ctl_t c,
                                             input logic nrdy, input logic srdy,
                                             input logic done);
    return {access, c, nrdy, srdy, done};
  endfunction

  // Register decode below the window half of the address space
  function automatic sel_e decode_reg(input logic [3:0] lo);
    if (lo[3])             return SEL_CORE;
    else if (lo == 4'h0)   return SEL_CTRL;
    else if (lo == 4'h1)   return SEL_CNT;
    else if (lo == 4'h2)   return SEL_RESUME;
    else                   return SEL_NONE;
  endfunction

endpackage

// File: rtl/blkdma_win_buf.sv
module blkdma_win_buf #(
  parameter int BLK_BYTES = 128,
  parameter int DW        = 8,
  localparam int OFF_W    = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             host_we,
  input  logic [OFF_W-1:0] host_off,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_q,
  input  logic             side_we,
  input  logic [OFF_W-1:0] side_ptr,
  input  logic [DW-1:0]    side_wdata,
  output logic [DW-1:0]    side_q
);

  logic [DW-1:0] mem [BLK_BYTES];

  always_ff @(posedge clk) begin
    if (host_we) mem[host_off] <= host_wdata;
    if (side_we) mem[side_ptr] <= side_wdata;
  end

  assign host_q = mem[host_off];
  assign side_q = mem[side_ptr];

  AST_ONE_WRITER: assert property (@(posedge clk) !(host_we && side_we)); // R7

endmodule

// File: rtl/blkdma_xfer_seq.sv
module blkdma_xfer_seq #(
  parameter int BLK_BYTES = 128,
  parameter int CW        = 8,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLK_BYTES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             start,
  input  logic [CW-1:0]    start_cnt,
  input  logic             dir,
  input  logic             win_rd,
  input  logic             win_wr,
  input  logic [OFF_W-1:0] win_off,
  input  logic             disc,
  input  logic             resume,
  input  logic             side_req,
  output logic             active,
  output logic             own,      // disk side owns the window
  output logic             dir_l,
  output logic [OFF_W-1:0] ptr,
  output logic [CW-1:0]    cnt,
  output logic             done,
  output logic             susp,
  output logic             side_ack,
  output logic             side_xfer
);

  logic host_end, side_end, last_blk;

  assign side_ack  = active && own && !susp;
  assign side_xfer = side_ack && side_req;
  assign side_end  = side_xfer && (ptr == LAST_OFF);
  assign host_end  = active && !own && (dir_l ? win_rd : win_wr) && (win_off == LAST_OFF);
  assign last_blk  = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; own <= 1'b0; dir_l <= 1'b0; ptr <= '0;
      cnt <= '0; done <= 1'b0; susp <= 1'b0;
    end else if (soft_rst) begin
      active <= 1'b0; own <= 1'b0; dir_l <= 1'b0; ptr <= '0;
      cnt <= '0; done <= 1'b0; susp <= 1'b0;
    end else if (start && !active) begin
      active <= 1'b1; own <= dir; dir_l <= dir; ptr <= '0;
      cnt <= start_cnt; done <= 1'b0; susp <= 1'b0;
    end else if (active) begin
      if (disc)      susp <= 1'b1;
      if (resume)    susp <= 1'b0;
      if (side_xfer) ptr  <= ptr + 1'b1;
      if (side_end) begin
        if (dir_l) own <= 1'b0;
        else if (last_blk) begin
          active <= 1'b0; cnt <= '0; own <= 1'b0; done <= 1'b1; susp <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1; own <= 1'b0;
        end
      end
      if (host_end) begin
        if (dir_l && last_blk) begin
          active <= 1'b0; cnt <= '0; own <= 1'b0; done <= 1'b1; susp <= 1'b0;
        end else begin
          if (dir_l) cnt <= cnt - 1'b1;
          own <= 1'b1;
          ptr <= '0;
        end
      end
    end
  end

  AST_ACTIVE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt != '0); // R2
  AST_PTR_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own) |-> ptr == '0); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && cnt != $past(cnt)) |-> cnt == CW'($past(cnt) - 1'b1)); // R4
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active) && !$past(soft_rst)) |-> done); // R6

endmodule

// File: rtl/blkdma_csr.sv
module blkdma_csr
  import blkdma_pkg::*;
#(
  parameter int BLK_BYTES = 128,
  parameter int DW        = 8,
  parameter int CW        = 8,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int AW       = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             active,
  input  logic             own,
  input  logic             susp,
  input  logic             done,
  input  logic [CW-1:0]    cnt,
  input  logic [DW-1:0]    buf_q,
  input  logic [DW-1:0]    core_rdata,
  input  logic             core_irq,
  output ctl_t             ctl,
  output logic             soft_rst,
  output logic             start,
  output logic [CW-1:0]    start_cnt,
  output logic             resume,
  output logic             win_rd,
  output logic             win_wr,
  output logic             buf_we,
  output logic [OFF_W-1:0] win_off,
  output logic             core_cs,
  output logic             core_we,
  output logic             irq,
  output logic             irq_oe
);

  sel_e sel;
  logic nrdy, srdy, access;

  assign sel     = host_addr[AW-1] ? SEL_WIN : decode_reg(host_addr[3:0]);
  assign win_off = host_addr[OFF_W-1:0];
  assign access  = !active;
  assign nrdy    = !active || own;
  assign srdy    = active && own && !susp;

  assign win_rd    = host_rd && (sel == SEL_WIN);
  assign win_wr    = host_wr && (sel == SEL_WIN);
  assign buf_we    = win_wr && !nrdy;
  assign soft_rst  = host_wr && (sel == SEL_CTRL) && host_wdata[7];
  assign start     = host_wr && (sel == SEL_CNT) && (host_wdata[CW-1:0] != '0);
  assign start_cnt = host_wdata[CW-1:0];
  assign resume    = host_wr && (sel == SEL_RESUME);
  assign core_cs   = (host_rd || host_wr) && (sel == SEL_CORE) && access;
  assign core_we   = core_cs && host_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else if (host_wr && sel == SEL_CTRL) ctl <= host_wdata[7] ? '0 : ctl_t'(host_wdata[6:3]);
  end

  always_comb begin
    unique case (sel)
      SEL_WIN:  host_rdata = nrdy ? '1 : buf_q;
      SEL_CTRL: host_rdata = pack_status(access, ctl, nrdy, srdy, done);
      SEL_CNT:  host_rdata = DW'(cnt);
      SEL_CORE: host_rdata = access ? core_rdata : '1;
      default:  host_rdata = '0;
    endcase
  end

  assign irq    = (ctl.en_rdy && active && !own) || (ctl.en_core && (core_irq || done));
  assign irq_oe = ctl.shared ? irq : 1'b1;

  AST_WIN_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && (!active || own)) |-> host_rdata == '1); // R7
  AST_CORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    core_cs |-> !active); // R8

endmodule

// File: rtl/blkdma_bridge.sv
module blkdma_bridge
  import blkdma_pkg::*;
#(
  parameter int BLK_BYTES = 128,
  parameter int DW        = 8,
  parameter int CW        = 8,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int AW       = OFF_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_irq,
  output logic          host_irq_oe,
  input  logic          scsi_req,
  output logic          scsi_ack,
  input  logic [DW-1:0] scsi_din,
  output logic [DW-1:0] scsi_dout,
  input  logic          scsi_disc,
  output logic          core_cs,
  output logic          core_we,
  input  logic [DW-1:0] core_rdata,
  input  logic          core_irq
);

  ctl_t             ctl;
  logic             soft_rst, start, resume, win_rd, win_wr, buf_we;
  logic [CW-1:0]    start_cnt, cnt;
  logic [OFF_W-1:0] win_off, ptr;
  logic             active, own, dir_l, done, susp, side_xfer;
  logic [DW-1:0]    buf_q;
  logic             side_we;

  assign side_we = side_xfer && dir_l;

  blkdma_csr #(.BLK_BYTES(BLK_BYTES), .DW(DW), .CW(CW)) u_csr (
    .clk, .rst_n, .host_addr, .host_wr, .host_rd, .host_wdata, .host_rdata,
    .active, .own, .susp, .done, .cnt, .buf_q, .core_rdata, .core_irq,
    .ctl, .soft_rst, .start, .start_cnt, .resume, .win_rd, .win_wr, .buf_we,
    .win_off, .core_cs, .core_we, .irq(host_irq), .irq_oe(host_irq_oe)
  );

  blkdma_xfer_seq #(.BLK_BYTES(BLK_BYTES), .CW(CW)) u_seq (
    .clk, .rst_n, .soft_rst, .start, .start_cnt, .dir(ctl.dir),
    .win_rd, .win_wr, .win_off, .disc(scsi_disc), .resume,
    .side_req(scsi_req), .active, .own, .dir_l, .ptr, .cnt, .done, .susp,
    .side_ack(scsi_ack), .side_xfer
  );

  blkdma_win_buf #(.BLK_BYTES(BLK_BYTES), .DW(DW)) u_buf (
    .clk, .host_we(buf_we), .host_off(win_off), .host_wdata, .host_q(buf_q),
    .side_we, .side_ptr(ptr), .side_wdata(scsi_din), .side_q(scsi_dout)
  );

  AST_ACK_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    scsi_ack |-> (!host_rdata[7] || !(host_rd && host_addr == '0))); // R12
  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(susp) && susp) |-> !scsi_ack); // R12

endmodule

// File: tb/blkdma_bridge_tb.sv
`timescale 1ns/1ps
module blkdma_bridge_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_irq, host_irq_oe;
  logic       scsi_req = 1'b0;
  logic       scsi_ack;
  logic [7:0] scsi_din = '0;
  logic [7:0] scsi_dout;
  logic       scsi_disc = 1'b0;
  logic       core_cs, core_we;
  logic [7:0] core_rdata = 8'h5A;
  logic       core_irq = 1'b0;

  always #2.5 clk = ~clk;

  blkdma_bridge dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;
  int seed;
  int req_pct = 100;
  bit side_on = 1'b0;
  int src_n = 0, sink_n = 0, core_hits = 0;
  logic [7:0] sink_mem [384];
  logic [7:0] wbuf [384];

  function automatic logic [7:0] src_pat(input int i);
    return 8'((i * 29 + seed) ^ (i >> 3));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1; #1 d = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  // Disk-side model: source in direction 1, sink in direction 0
  always begin
    bit take;
    @(negedge clk); #2;
    take = scsi_req && scsi_ack;
    if (take && sink_n < 384) begin sink_mem[sink_n] = scsi_dout; sink_n++; end
    @(posedge clk); #1;
    if (take) begin src_n++; scsi_din = src_pat(src_n); end
    scsi_req = side_on && (($urandom % 100) < req_pct);
  end

  always @(posedge clk) if (core_cs) core_hits++;

  // Poll status until the window is ready or the transfer is over
  task automatic wait_ready(input string req);
    logic [7:0] st;
    for (int k = 0; k < 3000; k++) begin
      hrd(8'h00, st);
      if (!st[2] || st[7]) return;
    end
    chk(req, 8'hEE, 8'h00);
  endtask

  task automatic start_xfer(input logic [7:0] ctl, input int n);
    src_n = 0; sink_n = 0; scsi_din = src_pat(0);
    hwr(8'h00, ctl);
    hwr(8'h01, 8'(n));
  endtask

  task automatic do_read(input logic [7:0] ctl, input int n);
    logic [7:0] d;
    start_xfer(ctl | 8'h40, n);
    hrd(8'h01, d); chk("R2 count readback", d, 8'(n));
    for (int b = 0; b < n; b++) begin
      wait_ready("R3 ready timeout");
      for (int i = 0; i < 128; i++) begin
        hrd(8'h80 + 8'(i), d);
        chk("R3 window data", d, src_pat(b * 128 + i));
      end
      if (b < n - 1) begin
        hrd(8'h01, d); chk("R4 count after block", d, 8'(n - b - 1));
      end
    end
    hrd(8'h00, d); chk("R6 status at end", d, 8'h85 | (ctl & 8'h38) | 8'h40);
  endtask

  task automatic do_write(input logic [7:0] ctl, input int n);
    logic [7:0] d;
    for (int i = 0; i < n * 128; i++) wbuf[i] = 8'($urandom);
    start_xfer(ctl & 8'hBF, n);
    for (int b = 0; b < n; b++) begin
      wait_ready("R5 ready timeout");
      for (int i = 0; i < 128; i++) hwr(8'h80 + 8'(i), wbuf[b * 128 + i]);
      if (b == 0) begin
        hrd(8'h00, d); chk("R5 not-ready after offset 127", d & 8'h04, 8'h04);
        hwr(8'h80 + 8'd100, ~wbuf[100]);
        hrd(8'h80 + 8'd3, d); chk("R7 locked window read", d, 8'hFF);
      end
    end
    wait_ready("R6 done timeout");
    repeat (2) @(negedge clk);
    chk("R5 drained byte count", 8'(sink_n >> 7), 8'(n));
    for (int i = 0; i < n * 128; i++) chk("R5 R7 drained data", sink_mem[i], wbuf[i]);
    hrd(8'h00, d); chk("R6 status at end", d, 8'h85 | (ctl & 8'h38));
    hrd(8'h01, d); chk("R6 count zero", d, 8'h00);
  endtask

  initial begin
    logic [7:0] d;
    int hits;
    seed = $urandom(32'd77);
    seed = seed & 32'hFF;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    side_on = 1'b1;

    hrd(8'h00, d); chk("R1 reset status", d, 8'h84);
    hrd(8'h01, d); chk("R1 reset count", d, 8'h00);
    hwr(8'h01, 8'h00);
    hrd(8'h00, d); chk("R2 zero count no start", d, 8'h84);

    hits = core_hits;
    hrd(8'h0A, d); chk("R8 core read idle", d, 8'h5A);
    chk("R8 core_cs idle", 8'(core_hits - hits), 8'd1);

    // Directed read of two blocks with lock checks
    start_xfer(8'h40, 2);
    hrd(8'h00, d); chk("R2 R13 status after start", d, 8'h46);
    hrd(8'h85, d); chk("R7 window read while filling", d, 8'hFF);
    hits = core_hits;
    hrd(8'h08, d); chk("R8 core read locked", d, 8'hFF);
    chk("R8 core_cs locked", 8'(core_hits - hits), 8'd0);
    for (int b = 0; b < 2; b++) begin
      wait_ready("R3 ready timeout");
      for (int i = 0; i < 128; i++) begin
        hrd(8'h80 + 8'(i), d); chk("R3 window data", d, src_pat(b * 128 + i));
      end
      if (b == 0) begin
        hrd(8'h01, d); chk("R4 count decrement", d, 8'h01);
        hrd(8'h00, d); chk("R4 refill status", d & 8'h07, 8'h06);
      end
    end
    hrd(8'h00, d); chk("R6 read done status", d, 8'hC5);
    chk("R9 no irq without enables", 8'(host_irq), 8'd0);
    chk("R10 oe unshared", 8'(host_irq_oe), 8'd1);

    // Write direction with core interrupt enable
    do_write(8'h10, 2);
    chk("R9 irq on done", 8'(host_irq), 8'd1);
    chk("R10 oe unshared", 8'(host_irq_oe), 8'd1);

    // Ready interrupt in shared mode
    start_xfer(8'h68, 1);
    @(negedge clk); #1;
    chk("R9 irq low while filling", 8'(host_irq), 8'd0);
    chk("R10 oe follows irq low", 8'(host_irq_oe), 8'd0);
    wait_ready("R9 ready timeout");
    @(negedge clk); #1;
    chk("R9 irq when window ready", 8'(host_irq), 8'd1);
    chk("R10 oe follows irq high", 8'(host_irq_oe), 8'd1);
    for (int i = 0; i < 128; i++) hrd(8'h80 + 8'(i), d);
    @(negedge clk); #1;
    chk("R9 irq drops after done", 8'(host_irq), 8'd0);
    chk("R10 oe drops", 8'(host_irq_oe), 8'd0);
    core_irq = 1'b1;
    hwr(8'h00, 8'h10);
    @(negedge clk); #1;
    chk("R9 core irq pass", 8'(host_irq), 8'd1);
    core_irq = 1'b0;

    // Suspend and resume
    start_xfer(8'h40, 1);
    repeat (10) @(posedge clk);
    @(negedge clk); scsi_disc = 1'b1;
    @(negedge clk); scsi_disc = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #2;
      chk("R12 ack held while suspended", 8'(scsi_ack), 8'd0);
    end
    hrd(8'h00, d); chk("R13 no disk-side ready when suspended", d & 8'h06, 8'h04);
    hwr(8'h02, 8'h00);
    hrd(8'h00, d); chk("R12 R13 resumed", d & 8'h02, 8'h02);
    wait_ready("R12 ready timeout");
    for (int i = 0; i < 128; i++) begin
      hrd(8'h80 + 8'(i), d); chk("R12 data across suspend", d, src_pat(i));
    end
    hrd(8'h00, d); chk("R6 done after resume", d, 8'hC5);

    // Soft reset mid transfer
    start_xfer(8'h70, 3);
    repeat (40) @(posedge clk);
    hwr(8'h00, 8'h80);
    hrd(8'h00, d); chk("R11 status after abort", d, 8'h84);
    hrd(8'h01, d); chk("R11 count after abort", d, 8'h00);

    // Random mix
    for (int it = 0; it < 4; it++) begin
      req_pct = 30 + int'($urandom % 70);
      if ($urandom % 2) do_read(8'h00, 1 + int'($urandom % 3));
      else              do_write(8'h00, 1 + int'($urandom % 3));
    end

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule